// File: doc/BRIEF.md
# 8-bit timer with waveform generation

This block is an 8-bit timer/counter with two output-compare channels, A and B. Each channel drives one waveform pin. The counter runs from a free-running 10-bit prescaler. It has four kinds of operation: plain counting to 0xFF, clear-on-compare with the period set by compare register A, fast (single-slope) PWM and phase-correct (dual-slope) PWM. Both PWM kinds can take TOP either as 0xFF or as compare register A.

Software reaches the block through three write ports. The control byte holds the two force-compare strobes, the high mode bit and the clock select. The configuration byte holds the two compare-output-mode fields and the two low mode bits. The third port loads the compare registers. The compare values are double-buffered while a PWM mode is active, so a new duty or period takes effect only at a cycle boundary. Three single-cycle event flags go to an interrupt controller outside the block: overflow, match A and match B.

Top module: `tmr8_wavegen`

## Requirements
- R1: While reset is held, `count`, all three flags, both wave pins and `ctl_rdata` are 0.
- R2: Clock select is control bits 2:0. Code 000 stops the counter. Codes 001, 010, 011, 100 and 101 advance it once every 1, 8, 64, 256 and 1024 clock cycles. Codes 110 and 111 stop it.
- R3: The mode is {control bit 3, configuration bits 1:0}. Modes 0, 4 and 6 count 0x00 to 0xFF and wrap. `ovf_flag` pulses for one cycle in the same cycle that `count` shows 0 after 0xFF. The period is 256 ticks. Mode 6 never behaves as PWM.
- R4: In mode 2, after `count` equals compare register A, it returns to 0. In non-PWM modes a compare write takes effect on the next clock, so a period change shows up at once.
- R5: `match_a_flag` and `match_b_flag` pulse for one cycle in the cycle after the counter has advanced from a value equal to that channel's compare register.
- R6: In non-PWM modes the channel field acts on a match as follows: 01 toggles the pin, 10 clears it and 11 sets it. A field of 00 holds the pin at 0. The A field is configuration bits 7:6 and the B field is bits 5:4.
- R7: In a non-PWM mode, a control write with bit 7 (A) or bit 6 (B) set applies that channel's field action to its pin on the next clock. This uses the mode in effect before the write. It sets no flag and leaves `count` unchanged.
- R8: In the PWM modes (1, 3, 5, 7), the force bits have no effect on the wave pins.
- R9: `ctl_rdata` reads bits 7:4 as 0, bit 3 as the high mode bit and bits 2:0 as the clock select.
- R10: Modes 3 and 7 are fast PWM. TOP is 0xFF in mode 3 and compare register A in mode 7. The counter wraps from TOP to 0, and `ovf_flag` pulses in the same cycle that `count` shows 0. With field 10, the pin is high from BOTTOM through the match value. With OCR = 0x40 and TOP = 0xFF, it is high for 65 of every 256 ticks. Field 11 inverts this.
- R11: Modes 1 and 5 are phase-correct PWM. TOP is 0xFF in mode 1 and compare register A in mode 5. The counter counts up to TOP and back down to 0, so the period is 2×TOP ticks. `ovf_flag` pulses at BOTTOM, in the cycle that `count` shows 1. With field 10, the pin clears on an up-count match and sets on a down-count match. Field 11 is the inverse.
- R12: In PWM modes, compare writes are held in a buffer. Fast PWM loads the buffer when the counter wraps at TOP. Phase-correct PWM loads it when the counter turns at TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: force A [7], force B [6], mode high [3], clock select [2:0] |
| ctl_rdata | output | 8 | Control byte readback |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Field A [7:6], field B [5:4], mode low [1:0] |
| ocra_we | input | 1 | Compare register A write strobe |
| ocrb_we | input | 1 | Compare register B write strobe |
| ocr_wdata | input | 8 | Compare write data |
| count | output | 8 | Counter value |
| ovf_flag | output | 1 | Overflow event pulse |
| match_a_flag | output | 1 | Channel A match pulse |
| match_b_flag | output | 1 | Channel B match pulse |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |

## Verification
The bench writes a new TOP partway through a period in fast and phase-correct PWM. A design without buffering, or one that loads the buffer at the wrong end of the slope, would shorten the current period instead of stretching only the next one. A new TOP written in clear-on-compare mode must shorten the period at once, which exposes a design that buffers in a non-PWM mode. Forced compares are checked for three things: a stray match flag, a counter that clears or moves, and any effect on the pin in PWM modes. The bench also checks where the overflow lands in each mode, since a design that flags at MAX in fast PWM or at TOP in phase-correct PWM shifts the overflow-to-count relation the bench samples.

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic [7:0]   ctl_wdata,
  output logic [7:0]   ctl_rdata,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_wdata,
  input  logic         ocra_we,
  input  logic         ocrb_we,
  input  logic [W-1:0] ocr_wdata,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         match_a_flag,
  output logic         match_b_flag,
  output logic         wave_a,
  output logic         wave_b
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [2:0]   cs;
  logic         mhi;
  logic [1:0]   mlo, coma, comb;
  logic [W-1:0] cnt, bufa, bufb, ocra_q, ocrb_q;
  logic         up, wa, wb;
  logic [9:0]   pre;
  logic         tick;

  wire [2:0] mode  = {mhi, mlo};
  wire       pwm   = mode[0];
  wire       fast  = mode[0] & mode[1];
  wire       phase = mode[0] & ~mode[1];
  wire       top_a = (mode == 3'd2) || (mode == 3'd5) || (mode == 3'd7);
  wire [W-1:0] top = top_a ? ocra_q : MAXV;

  wire unused_bits = ^{ctl_wdata[5:4], cfg_wdata[3:2]};

  always_comb begin
    case (cs)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[5:0];
      3'd4:    tick = &pre[7:0];
      3'd5:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase
  end

  wire at_top  = tick & (cnt == top);
  wire hit_a   = tick & (cnt == ocra_q);
  wire hit_b   = tick & (cnt == ocrb_q);
  wire ovf_evt = phase ? (tick & ~up & (cnt == ZERO))
               : fast  ? at_top
               :         (tick & (cnt == MAXV));
  wire upd     = fast ? at_top : (phase & at_top & up);
  wire frc_a   = ctl_we & ctl_wdata[7] & ~pwm;
  wire frc_b   = ctl_we & ctl_wdata[6] & ~pwm;

  wire [W-1:0] bufa_n = ocra_we ? ocr_wdata : bufa;
  wire [W-1:0] bufb_n = ocrb_we ? ocr_wdata : bufb;

  function automatic logic wave_nx(input logic cur, input logic [1:0] com,
                                   input logic hit, input logic frc);
    logic nx;
    nx = cur;
    if (!pwm) begin
      if (hit || frc)
        case (com)
          2'b01:   nx = ~cur;
          2'b10:   nx = 1'b0;
          2'b11:   nx = 1'b1;
          default: nx = cur;
        endcase
    end else if (fast && at_top) begin
      if (com == 2'b10) nx = 1'b1;
      else if (com == 2'b11) nx = 1'b0;
    end else if (hit) begin
      if (com == 2'b10) nx = (fast || up) ? 1'b0 : 1'b1;
      else if (com == 2'b11) nx = (fast || up) ? 1'b1 : 1'b0;
    end
    return nx;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs <= '0; mhi <= 1'b0; mlo <= '0; coma <= '0; comb <= '0;
      cnt <= '0; up <= 1'b1; pre <= '0;
      bufa <= '0; bufb <= '0; ocra_q <= '0; ocrb_q <= '0;
      wa <= 1'b0; wb <= 1'b0;
      ovf_flag <= 1'b0; match_a_flag <= 1'b0; match_b_flag <= 1'b0;
    end else begin
      pre <= pre + 10'd1;
      if (ctl_we) begin
        mhi <= ctl_wdata[3];
        cs  <= ctl_wdata[2:0];
      end
      if (cfg_we) begin
        coma <= cfg_wdata[7:6];
        comb <= cfg_wdata[5:4];
        mlo  <= cfg_wdata[1:0];
      end
      bufa <= bufa_n;
      bufb <= bufb_n;
      if (!pwm || upd) begin
        ocra_q <= bufa_n;
        ocrb_q <= bufb_n;
      end
      if (tick) begin
        if (phase) begin
          if (up) begin
            if (cnt == top) begin
              up  <= 1'b0;
              cnt <= (cnt == ZERO) ? ZERO : cnt - ONE;
            end else cnt <= cnt + ONE;
          end else if (cnt == ZERO) begin
            up  <= 1'b1;
            cnt <= (top == ZERO) ? ZERO : ONE;
          end else cnt <= cnt - ONE;
        end else if ((fast || mode == 3'd2) && cnt == top) cnt <= ZERO;
        else cnt <= cnt + ONE;
      end
      wa <= wave_nx(wa, coma, hit_a, frc_a);
      wb <= wave_nx(wb, comb, hit_b, frc_b);
      ovf_flag     <= ovf_evt;
      match_a_flag <= hit_a;
      match_b_flag <= hit_b;
    end
  end

  assign count     = cnt;
  assign ctl_rdata = {4'b0000, mhi, cs};
  assign wave_a    = (coma == 2'b00 || (pwm && coma == 2'b01)) ? 1'b0 : wa;
  assign wave_b    = (comb == 2'b00 || (pwm && comb == 2'b01)) ? 1'b0 : wb;
endmodule

// File: rtl/tmr8_wavegen_chk.sv
module tmr8_wavegen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   cs,
  input logic [2:0]   mode,
  input logic [W-1:0] count,
  input logic         ovf,
  input logic         mat_a
);
  localparam logic [W-1:0] MAXV = '1;

  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'd0 || cs >= 3'd6) |=> count == $past(count));

  a_r3_ovf_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !$past(mode[0])) |-> (count == '0 && $past(count) == MAXV));

  a_r4_ctc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mat_a && $past(mode) == 3'd2) |-> count == '0);

  a_r10_fast_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && $past(mode[1:0]) == 2'b11) |-> count == '0);

  a_r11_phase_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && $past(mode[1:0]) == 2'b01) |-> $past(count) == '0);
endmodule

bind tmr8_wavegen tmr8_wavegen_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .mode(mode),
  .count(count), .ovf(ovf_flag), .mat_a(match_a_flag)
);

// File: tb/tmr8_wavegen_tb_top.sv
module tmr8_wavegen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, cfg_we = 1'b0, ocra_we = 1'b0, ocrb_we = 1'b0;
  logic [7:0] ctl_wdata = '0, cfg_wdata = '0, ocr_wdata = '0;
  logic [7:0] ctl_rdata, count;
  logic ovf_flag, match_a_flag, match_b_flag, wave_a, wave_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr8_wavegen dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ocra_we(ocra_we), .ocrb_we(ocrb_we), .ocr_wdata(ocr_wdata),
    .count(count), .ovf_flag(ovf_flag), .match_a_flag(match_a_flag),
    .match_b_flag(match_b_flag), .wave_a(wave_a), .wave_b(wave_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_a(input logic [7:0] v);
    @(negedge clk); ocr_wdata = v; ocra_we = 1'b1;
    @(negedge clk); ocra_we = 1'b0;
  endtask

  task automatic wr_b(input logic [7:0] v);
    @(negedge clk); ocr_wdata = v; ocrb_we = 1'b1;
    @(negedge clk); ocrb_we = 1'b0;
  endtask

  task automatic wait_ev(input int which, input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if ((which == 0 && ovf_flag) || (which == 1 && match_a_flag) ||
          (which == 2 && match_b_flag)) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 flags", {ovf_flag, match_a_flag, match_b_flag}, 0);
    chk("R1 waves", {wave_a, wave_b}, 0);
    chk("R1 rdata", ctl_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_readback;
    wr_ctl(8'hCD);
    chk("R9 rdata", ctl_rdata, 8'h0D);
    wr_ctl(8'h00);
  endtask

  task automatic t_normal;
    int n;
    wr_cfg(8'h00); wr_a(8'd5); wr_ctl(8'h01);
    wait_ev(0, 300, n);
    chk("R3 count at ovf", count, 0);
    wait_ev(0, 300, n);
    chk("R3 mode0 period", n, 256);
    wr_ctl(8'h09); wr_cfg(8'h02);
    wait_ev(0, 300, n);
    wait_ev(0, 300, n);
    chk("R3 mode6 period", n, 256);
    chk("R3 mode6 count at ovf", count, 0);
  endtask

  task automatic t_prescale;
    logic [7:0] c0;
    wr_cfg(8'h00);
    wr_ctl(8'h02); c0 = count; repeat (80) @(negedge clk);
    chk("R2 div8", 8'(count - c0), 10);
    wr_ctl(8'h03); c0 = count; repeat (640) @(negedge clk);
    chk("R2 div64", 8'(count - c0), 10);
    wr_ctl(8'h05); c0 = count; repeat (2048) @(negedge clk);
    chk("R2 div1024", 8'(count - c0), 2);
    wr_ctl(8'h06); c0 = count; repeat (50) @(negedge clk);
    chk("R2 code110 stopped", 8'(count - c0), 0);
    wr_ctl(8'h07); c0 = count; repeat (50) @(negedge clk);
    chk("R2 code111 stopped", 8'(count - c0), 0);
  endtask

  task automatic t_ctc;
    int n;
    logic w0;
    wr_ctl(8'h00); wr_cfg(8'h42); wr_a(8'd9); wr_b(8'd4); wr_ctl(8'h01);
    wait_ev(1, 400, n);
    chk("R4 count after match", count, 0);
    w0 = wave_a;
    wait_ev(2, 40, n);
    chk("R5 match_b delay", n, 5);
    chk("R5 count at match_b", count, 5);
    wait_ev(1, 40, n);
    chk("R4 period", n, 5);
    chk("R6 toggle", wave_a, !w0);
    wr_a(8'd14);
    wait_ev(1, 40, n);
    chk("R4 direct write", n, 13);
    chk("R6 toggle again", wave_a, w0);
  endtask

  task automatic t_force;
    logic [7:0] c0;
    wr_ctl(8'h00);
    wr_cfg(8'hA2); wr_ctl(8'h80);
    chk("R7 force clear", wave_a, 0);
    wr_cfg(8'hF2); c0 = count;
    wr_ctl(8'hC0);
    chk("R7 force set a", wave_a, 1);
    chk("R7 force set b", wave_b, 1);
    chk("R7 no flags", {ovf_flag, match_a_flag, match_b_flag}, 0);
    chk("R7 count kept", count, c0);
    wr_cfg(8'h52); wr_ctl(8'h80);
    chk("R7 force toggle a", wave_a, 0);
    chk("R7 b untouched", wave_b, 1);
    wr_ctl(8'h08); wr_cfg(8'hA2); wr_ctl(8'h48);
    chk("R3 mode6 force b", wave_b, 0);
    wr_ctl(8'h00); wr_cfg(8'hF2); wr_ctl(8'h80);
    chk("R7 force set again", wave_a, 1);
    wr_cfg(8'hB3); wr_ctl(8'h80);
    chk("R8 ignored mode3", wave_a, 1);
    wr_cfg(8'hB1); wr_ctl(8'h88);
    chk("R8 ignored mode5", wave_a, 1);
    wr_ctl(8'h00);
  endtask

  task automatic t_fast_duty;
    int n, hi;
    wr_ctl(8'h00); wr_cfg(8'h00); wr_a(8'h40); wr_cfg(8'h83); wr_ctl(8'h01);
    wait_ev(0, 600, n);
    chk("R10 count at ovf", count, 0);
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (wave_a) hi++;
      @(negedge clk);
    end
    chk("R10 duty", hi, 65);
  endtask

  task automatic t_fast_buf;
    int n;
    wr_ctl(8'h00); wr_cfg(8'h00); wr_a(8'd20); wr_cfg(8'h03); wr_ctl(8'h09);
    wait_ev(0, 600, n);
    chk("R10 mode7 count at ovf", count, 0);
    wr_a(8'd30);
    wait_ev(0, 100, n);
    chk("R12 fast current period kept", n, 19);
    wait_ev(0, 100, n);
    chk("R12 fast next period", n, 31);
  endtask

  task automatic t_phase;
    int n, mx;
    wr_ctl(8'h00); wr_cfg(8'h00); wr_a(8'd10); wr_cfg(8'h01); wr_ctl(8'h09);
    wait_ev(0, 800, n);
    chk("R11 count at ovf", count, 1);
    mx = 0; n = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (count > mx) mx = count;
      if (ovf_flag) begin n = i; break; end
    end
    chk("R11 period", n, 20);
    chk("R11 peak", mx, 10);
    wr_a(8'd6);
    wait_ev(0, 100, n);
    chk("R12 phase current period kept", n, 18);
    wait_ev(0, 100, n);
    chk("R12 phase next period", n, 12);
    wr_ctl(8'h00);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  initial begin
    t_reset();
    t_readback();
    t_normal();
    t_prescale();
    t_ctc();
    t_force();
    t_fast_duty();
    t_fast_buf();
    t_phase();
    finish_up();
  end
endmodule